// File: doc/BRIEF.md
# Ranged Cache Line Maintenance Walker

This block applies a maintenance operation to the part of a direct-mapped data cache that lies inside an inclusive address range. A command carries an operation code and two byte addresses. The walker aligns both addresses down to line boundaries. It then steps one line address at a time from the low line to the high line, and for each one it looks up the tag store entry that the line maps to. Only a line whose stored tag matches the line address and whose valid bit is set is a candidate for change.

Three operations are supported. Drop discards the line and loses any dirty data, which suits a buffer that a device is about to overwrite. Clean copies dirty data out to memory and keeps the line resident, so later reads still hit. Flush copies dirty data out and then discards the line. Dirty data leaves through a request/acknowledge port that carries the line-aligned address. The cache line data path is outside this block.

An abort input lets an interrupt cancel a walk. Lines already handled keep their new state. Software recovers by issuing the same command again, which walks the whole range from its first line.

Top module: `line_sweep_engine`

## Requirements
- R1: The lines walked run from the line holding `cmd_lo` (address bits above the line offset) through the line holding `cmd_hi`, both included. An entry whose index and tag match a line address outside that span is never modified.
- R2: Op code 2'b01 (drop) clears the valid bit of every matching line. It never raises `wb_req`, whether or not the line is dirty.
- R3: Op code 2'b10 (clean) raises `wb_req` for each matching dirty line, with `wb_addr` equal to the line address and zero offset bits. After `wb_ack`, it writes that entry back as valid and not dirty.
- R4: Op code 2'b11 (flush) writes back each matching dirty line as in R3, then clears its valid bit. A matching clean line is invalidated with no write-back.
- R5: A clean line is never written back, whatever the op. Entries that miss (invalid, or tag differs) are not modified.
- R6: A line that needs no write-back takes one cycle. A walk of N such lines raises `done` N cycles after the accepting edge. During a write-back, `wb_req` and `wb_addr` hold steady until `wb_ack`, and the walk stalls for that time.
- R7: `busy` rises on the edge that accepts a command and falls on the edge that raises `done`. `done` is high for one cycle.
- R8: If the aligned high line is below the aligned low line, the command raises `done` on the cycle after acceptance. `busy` does not rise and no entry changes.
- R9: A command presented while `busy` is high is ignored, and so is a command with op code 2'b00.
- R10: `abort` during a line with no write-back in flight returns the walker to idle on the next edge without `done`. `abort` during a write-back keeps `wb_req` up until `wb_ack`, applies that line's update, and returns to idle on that edge without `done`. Re-issuing the command walks the full range again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code: 01 drop, 10 clean, 11 flush, 00 none |
| cmd_lo | input | ADDR_W | Low byte address of the range |
| cmd_hi | input | ADDR_W | High byte address of the range |
| abort | input | 1 | Cancel the walk in progress |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| arr_idx | output | log2(SETS) | Tag store index being examined and updated |
| arr_tag | input | ADDR_W-log2(LINE_BYTES)-log2(SETS) | Stored tag at `arr_idx` |
| arr_valid | input | 1 | Stored valid bit at `arr_idx` |
| arr_dirty | input | 1 | Stored dirty bit at `arr_idx` |
| arr_we | output | 1 | Write strobe for the entry at `arr_idx` |
| arr_wr_valid | output | 1 | Valid bit to write |
| arr_wr_dirty | output | 1 | Dirty bit to write |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Line-aligned address of the line being written back |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
The bench uses a high address that is not line aligned and sits just below a dirty in-range entry. A walker that rounded up, or that stopped one line early, would corrupt or miss that entry. It also issues a range whose high address is numerically lower than the low address but lies in the same line, which must still handle one line; a walker that compared raw addresses would treat it as empty. Entries that share an index with in-range lines but carry another tag must keep their dirty data; a walker that skipped the tag compare would write them back or drop them. The bench aborts once mid-walk and once while an acknowledge is held back, then adds a new dirty line before re-issuing the command. A walker that dropped the request early, reported completion, or resumed instead of restarting would leave the wrong entries dirty or write back the wrong number of lines.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_DROP  = 2'b01,
    OP_CLEAN = 2'b10,
    OP_FLUSH = 2'b11
  } maint_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WALK = 2'b01,
    ST_WB   = 2'b10
  } walk_state_e;

  typedef enum logic [1:0] {
    ACT_SKIP  = 2'b00,
    ACT_DROP  = 2'b01,
    ACT_WRITE = 2'b10
  } line_act_e;

endpackage

// File: rtl/lsw_cursor.sv
module lsw_cursor #(
  parameter int LA_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            active,
  input  logic [LA_W-1:0] lo_line,
  input  logic [LA_W-1:0] hi_line,
  output logic [LA_W-1:0] cur_line,
  output logic            is_last,
  output logic            empty
);

  logic [LA_W-1:0] first_q, cur_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      cur_q   <= '0;
      last_q  <= '0;
    end else if (load) begin
      first_q <= lo_line;
      cur_q   <= lo_line;
      last_q  <= hi_line;
    end else if (step) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign cur_line = cur_q;
  assign is_last  = (cur_q == last_q);
  assign empty    = (hi_line < lo_line);

  // R1: while walking, the cursor never leaves the loaded span
  assert_cursor_span_R1: assert property (@(posedge clk) disable iff (rst)
    active |-> ((cur_q >= first_q) && (cur_q <= last_q)));

endmodule

// File: rtl/lsw_classify.sv
module lsw_classify
  import lsw_pkg::*;
#(
  parameter int TW = 8
) (
  input  maint_op_e       op,
  input  logic [TW-1:0]   cur_tag,
  input  logic [TW-1:0]   arr_tag,
  input  logic            arr_valid,
  input  logic            arr_dirty,
  output line_act_e       act,
  output logic            keep_valid
);

  logic hit;

  assign hit        = arr_valid && (arr_tag == cur_tag);
  assign keep_valid = (op == OP_CLEAN);

  always_comb begin
    act = ACT_SKIP;
    if (hit) begin
      if (arr_dirty && (op == OP_CLEAN || op == OP_FLUSH)) begin
        act = ACT_WRITE;
      end else if (op == OP_DROP || op == OP_FLUSH) begin
        act = ACT_DROP;
      end
    end
  end

endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_valid,
  input  maint_op_e cmd_op,
  input  logic      empty,
  input  logic      abort,
  input  line_act_e act,
  input  logic      is_last,
  input  logic      wb_ack,
  output logic      busy,
  output logic      done,
  output logic      load,
  output logic      step,
  output logic      arr_we,
  output logic      wb_req,
  output maint_op_e op
);

  walk_state_e state_q, state_d;
  maint_op_e   op_q;
  logic        pend_q, pend_d;
  logic        done_q, done_d;
  logic        cmd_ok;

  assign cmd_ok = cmd_valid && (cmd_op != OP_NONE);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    arr_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (cmd_ok) begin
          load = 1'b1;
          if (empty) done_d  = 1'b1;
          else       state_d = ST_WALK;
        end
      end
      ST_WALK: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (act == ACT_WRITE) begin
          state_d = ST_WB;
        end else begin
          arr_we = (act == ACT_DROP);
          step   = 1'b1;
          if (is_last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WB: begin
        if (abort) pend_d = 1'b1;
        if (wb_ack) begin
          arr_we = 1'b1;
          if (pend_q || abort) begin
            state_d = ST_IDLE;
          end else begin
            step = 1'b1;
            if (is_last) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_WALK;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      if (load) op_q <= cmd_op;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign wb_req = (state_q == ST_WB);
  assign done   = done_q;
  assign op     = op_q;

  // R6: a pending write-back request is never withdrawn before acknowledge
  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> wb_req);

  // R7: completion is reported only once the walker is idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: a drop walk never asks memory for a write-back
  assert_drop_no_wb_R2: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (op_q != OP_DROP));

  // R10: abort with no write-back outstanding ends the walk on the next edge
  assert_abort_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !wb_req && abort) |=> (!busy && !done));

endmodule

// File: rtl/line_sweep_engine.sv
module line_sweep_engine
  import lsw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 16
) (
  input  logic                                                 clk,
  input  logic                                                 rst,
  input  logic                                                 cmd_valid,
  input  logic [1:0]                                           cmd_op,
  input  logic [ADDR_W-1:0]                                    cmd_lo,
  input  logic [ADDR_W-1:0]                                    cmd_hi,
  input  logic                                                 abort,
  output logic                                                 busy,
  output logic                                                 done,
  output logic [$clog2(SETS)-1:0]                              arr_idx,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(SETS)-1:0]    arr_tag,
  input  logic                                                 arr_valid,
  input  logic                                                 arr_dirty,
  output logic                                                 arr_we,
  output logic                                                 arr_wr_valid,
  output logic                                                 arr_wr_dirty,
  output logic                                                 wb_req,
  output logic [ADDR_W-1:0]                                    wb_addr,
  input  logic                                                 wb_ack
);

  localparam int OFS  = $clog2(LINE_BYTES);
  localparam int IW   = $clog2(SETS);
  localparam int LA_W = ADDR_W - OFS;
  localparam int TW   = LA_W - IW;

  logic [LA_W-1:0] lo_line, hi_line, cur_line;
  logic            is_last, empty, load, step, keep_valid;
  maint_op_e       op;
  line_act_e       act;
  logic            unused_offsets;

  assign lo_line        = cmd_lo[ADDR_W-1:OFS];
  assign hi_line        = cmd_hi[ADDR_W-1:OFS];
  assign unused_offsets = ^{cmd_lo[OFS-1:0], cmd_hi[OFS-1:0]};

  lsw_cursor #(.LA_W(LA_W)) u_cursor (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .active   (busy),
    .lo_line  (lo_line),
    .hi_line  (hi_line),
    .cur_line (cur_line),
    .is_last  (is_last),
    .empty    (empty)
  );

  lsw_classify #(.TW(TW)) u_classify (
    .op         (op),
    .cur_tag    (cur_line[LA_W-1:IW]),
    .arr_tag    (arr_tag),
    .arr_valid  (arr_valid),
    .arr_dirty  (arr_dirty),
    .act        (act),
    .keep_valid (keep_valid)
  );

  lsw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (maint_op_e'(cmd_op)),
    .empty     (empty),
    .abort     (abort),
    .act       (act),
    .is_last   (is_last),
    .wb_ack    (wb_ack),
    .busy      (busy),
    .done      (done),
    .load      (load),
    .step      (step),
    .arr_we    (arr_we),
    .wb_req    (wb_req),
    .op        (op)
  );

  assign arr_idx      = cur_line[IW-1:0];
  assign arr_wr_valid = keep_valid && wb_req;
  assign arr_wr_dirty = 1'b0;
  assign wb_addr      = {cur_line, {OFS{1'b0}}};

  // R6: the address offered to memory stays put while the request waits
  assert_wb_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> $stable(wb_addr));

endmodule

// File: tb/line_sweep_engine_bench.sv
module line_sweep_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int TW = 8;
  localparam logic [1:0] OPN = 2'b00, OPD = 2'b01, OPC = 2'b10, OPF = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_lo = '0, cmd_hi = '0;
  logic abort = 1'b0;
  logic busy, done, arr_we, arr_wr_valid, arr_wr_dirty, wb_req;
  logic [IW-1:0] arr_idx;
  logic [TW-1:0] arr_tag;
  logic arr_valid, arr_dirty;
  logic [AW-1:0] wb_addr;
  logic wb_ack = 1'b0;

  logic [TW-1:0] m_tag [16];
  logic          m_v   [16];
  logic          m_d   [16];

  int total = 0, failed = 0;
  int ack_lat = 1, wait_c = 0, wb_cnt = 0, done_cnt = 0;
  logic [AW-1:0] wb_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_sweep_engine u_line_sweep_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .abort(abort), .busy(busy), .done(done),
    .arr_idx(arr_idx), .arr_tag(arr_tag), .arr_valid(arr_valid), .arr_dirty(arr_dirty),
    .arr_we(arr_we), .arr_wr_valid(arr_wr_valid), .arr_wr_dirty(arr_wr_dirty),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
  );

  assign arr_tag   = m_tag[arr_idx];
  assign arr_valid = m_v[arr_idx];
  assign arr_dirty = m_d[arr_idx];

  always @(posedge clk) begin
    if (arr_we) begin
      m_v[arr_idx] <= arr_wr_valid;
      m_d[arr_idx] <= arr_wr_dirty;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  // memory responder: acknowledges after ack_lat cycles of request
  initial forever begin
    @(negedge clk);
    if (wb_ack) wb_ack = 1'b0;
    else if (wb_req) begin
      wait_c++;
      if (wait_c >= ack_lat) begin
        wb_ack = 1'b1; wb_cnt++; wb_last = wb_addr; wait_c = 0;
      end
    end else wait_c = 0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_line(input int i, input logic [TW-1:0] t, input logic v, input logic d);
    m_tag[i] = t; m_v[i] = v; m_d[i] = d;
  endtask

  task automatic std_fill();
    for (int i = 0; i < 16; i++) set_line(i, 8'hAA, 1'b0, 1'b0);
    set_line(2, 8'h12, 1, 1);
    set_line(3, 8'h12, 1, 1);
    set_line(4, 8'h12, 1, 0);
    set_line(5, 8'h34, 1, 1);
    set_line(6, 8'h12, 0, 0);
    set_line(7, 8'h12, 1, 1);
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    cmd_op = op; cmd_lo = lo; cmd_hi = hi; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk(busy == 0, "R7", "busy after reset", busy, 0);
    chk(done == 0, "R7", "done after reset", done, 0);
    chk(wb_req == 0, "R6", "wb_req after reset", wb_req, 0);
  endtask

  task automatic t_drop();
    int c, w0;
    std_fill(); w0 = wb_cnt;
    issue(OPD, 16'h1234, 16'h126F);
    wait_done(c);
    chk(c == 4, "R6", "drop cycles for 4 lines", c, 4);
    chk(m_v[3] == 0, "R2", "dirty line dropped", m_v[3], 0);
    chk(m_v[4] == 0, "R2", "clean line dropped", m_v[4], 0);
    chk(wb_cnt == w0, "R2", "no write-back on drop", wb_cnt - w0, 0);
    chk(m_v[5] && m_d[5], "R5", "tag mismatch untouched", {m_v[5], m_d[5]}, 3);
    chk(m_v[2] && m_d[2], "R1", "line below range kept", {m_v[2], m_d[2]}, 3);
    chk(m_v[7] && m_d[7], "R1", "line above aligned hi kept", {m_v[7], m_d[7]}, 3);
    chk(busy == 0, "R7", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R7", "done lasts one cycle", done, 0);
  endtask

  task automatic t_clean();
    int c, w0;
    ack_lat = 3; std_fill(); w0 = wb_cnt;
    issue(OPC, 16'h1234, 16'h126F);
    wait_done(c);
    chk(c == 7, "R6", "clean cycles with 3-cycle stall", c, 7);
    chk(wb_cnt - w0 == 1, "R3", "one write-back", wb_cnt - w0, 1);
    chk(wb_last == 16'h1230, "R3", "write-back address", wb_last, 16'h1230);
    chk(m_v[3] == 1 && m_d[3] == 0, "R3", "line valid and clean", {m_v[3], m_d[3]}, 2);
    chk(m_v[4] == 1 && m_d[4] == 0, "R5", "clean line left alone", {m_v[4], m_d[4]}, 2);
    chk(m_d[5] == 1, "R5", "mismatch keeps dirty", m_d[5], 1);
    @(negedge clk);
  endtask

  task automatic t_flush();
    int c, w0;
    ack_lat = 1; std_fill(); w0 = wb_cnt;
    issue(OPF, 16'h1234, 16'h126F);
    wait_done(c);
    chk(wb_cnt - w0 == 1, "R4", "flush write-back count", wb_cnt - w0, 1);
    chk(wb_last == 16'h1230, "R4", "flush address", wb_last, 16'h1230);
    chk(m_v[3] == 0, "R4", "dirty line invalid", m_v[3], 0);
    chk(m_v[4] == 0, "R4", "clean hit invalid", m_v[4], 0);
    chk(m_v[5] && m_d[5], "R5", "mismatch untouched", {m_v[5], m_d[5]}, 3);
    @(negedge clk);
  endtask

  task automatic t_empty_and_single();
    int c, w0, d0;
    std_fill(); w0 = wb_cnt;
    issue(OPF, 16'h1270, 16'h1260);
    d0 = done_cnt;
    wait_done(c);
    chk(c == 0, "R8", "empty done next cycle", c, 0);
    chk(busy == 0, "R8", "busy never rises", busy, 0);
    @(negedge clk);
    chk(wb_cnt == w0 && m_v[3] && m_v[4], "R8", "no change on empty", wb_cnt - w0, 0);
    issue(OPD, 16'h1238, 16'h1231);
    wait_done(c);
    chk(c == 1, "R1", "same line hi<lo walks one line", c, 1);
    chk(m_v[3] == 0 && m_v[4] == 1, "R1", "only that line dropped", {m_v[3], m_v[4]}, 1);
    if (d0 < 0) d0 = 0;
    @(negedge clk);
  endtask

  task automatic t_ignore();
    int c, w0, d0;
    std_fill(); w0 = wb_cnt; d0 = done_cnt;
    issue(OPC, 16'h0000, 16'h00FF);
    @(negedge clk); @(negedge clk);
    issue(OPF, 16'h1230, 16'h123F);
    wait_done(c);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R9", "second command not started", busy, 0);
    chk(done_cnt - d0 == 1, "R9", "single completion", done_cnt - d0, 1);
    chk(m_v[3] && m_d[3] && wb_cnt == w0, "R9", "line of ignored flush kept", {m_v[3], m_d[3]}, 3);
    d0 = done_cnt;
    issue(OPN, 16'h1230, 16'h123F);
    chk(busy == 0, "R9", "op 00 not accepted", busy, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 && m_v[3] && m_d[3], "R9", "op 00 no effect", done_cnt - d0, 0);
  endtask

  task automatic t_abort_walk();
    int c, w0, d0;
    ack_lat = 1; std_fill(); set_line(10, 8'h12, 1, 1);
    w0 = wb_cnt; d0 = done_cnt;
    issue(OPF, 16'h1200, 16'h12FF);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(busy == 0, "R10", "abort mid walk idles", busy, 0);
    repeat (2) @(negedge clk);
    chk(done_cnt == d0, "R10", "no done on abort", done_cnt - d0, 0);
    chk(wb_cnt == w0 && m_d[10] && m_d[2], "R10", "unreached lines kept", wb_cnt - w0, 0);
    set_line(9, 8'h12, 1, 1);
    issue(OPF, 16'h1200, 16'h12FF);
    wait_done(c);
    chk(wb_cnt - w0 == 5, "R10", "restart writes all dirty", wb_cnt - w0, 5);
    chk(!m_v[2] && !m_v[3] && !m_v[4] && !m_v[7] && !m_v[9] && !m_v[10], "R10",
        "restart invalidates range", {m_v[2], m_v[3], m_v[4], m_v[7], m_v[9], m_v[10]}, 0);
    chk(m_v[5] && m_d[5], "R5", "mismatch survives restart", {m_v[5], m_d[5]}, 3);
    @(negedge clk);
  endtask

  task automatic t_abort_wb();
    int n, w0, d0;
    ack_lat = 6; std_fill(); w0 = wb_cnt; d0 = done_cnt;
    issue(OPF, 16'h1234, 16'h126F);
    n = 0;
    while (!wb_req && n < 20) begin @(negedge clk); n++; end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(wb_req == 1, "R10", "request held through abort", wb_req, 1);
    chk(busy == 1, "R10", "busy until ack", busy, 1);
    n = 0;
    while (busy && n < 20) begin @(negedge clk); n++; end
    chk(busy == 0, "R10", "idle after ack", busy, 0);
    chk(wb_cnt - w0 == 1, "R10", "in-flight write-back finished", wb_cnt - w0, 1);
    chk(m_v[3] == 0, "R10", "processed line updated", m_v[3], 0);
    chk(m_v[4] == 1, "R10", "later line untouched", m_v[4], 1);
    repeat (2) @(negedge clk);
    chk(done_cnt == d0, "R10", "no done after abort", done_cnt - d0, 0);
    ack_lat = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    std_fill();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_drop();
    t_clean();
    t_flush();
    t_empty_and_single();
    t_ignore();
    t_abort_walk();
    t_abort_wb();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule